// File: doc/BRIEF.md
# Protected-Write Watchdog Timer

This block supervises software by counting ticks of a 32.768 kHz timebase enable. When it is enabled and software does not refresh it before a programmable timeout, it raises a system reset request or, if selected, a high-priority interrupt request that the global interrupt disable cannot mask. A power-supply-monitor event disables it, and one prescale code asks for an immediate reset.

Software sees one 8-bit control/status register on a simple strobe bus. The register is protected: a write changes it only if the bus transaction just before it was an arming write to the same register. Any other transaction in between, read or write, throws the arming away. The timeout status flag stays set through the watchdog's own reset and is lost only by a software write of 0 or an external hardware reset.

Top module: `wdt_guard`

## Requirements
- R1: After external reset (`rst_n` low) the register reads 0x10 and both request outputs are low. Readback layout: bits [7:4] prescale code, bit 3 interrupt-mode select, bit 2 timeout status, bit 1 enable, bit 0 armed flag.
- R2: A write to the register with data bit 0 = 1 while not armed only arms. The next transaction consumes the arming. If that transaction is a write to the register, the write is committed. A read, or a write to another address, cancels it. A write to the register while not armed with bit 0 = 0 is ignored.
- R3: With enable set and prescale code p in 0..7, the counter advances only on cycles where `tick` is high. The timeout fires on tick number 2^(p+9) counted from the enabling write.
- R4: A timeout with interrupt mode 0 gives a one-cycle pulse on `rst_req` in the cycle after the final tick. In that same cycle the enable bit reads 0 and the status bit reads 1.
- R5: A timeout with interrupt mode 1 gives a one-cycle pulse on `irq_req` instead. Enable stays 1 and the counter restarts from zero, so further pulses follow at the same period.
- R6: Prescale code 8 with enable set gives an `rst_req` pulse in the cycle after the committing write, whatever the interrupt mode. It then clears enable and sets status.
- R7: Prescale codes 9 to 15 never time out.
- R8: A committed write restarts the count from zero, and writing enable = 1 refreshes the watchdog. A commit on the same cycle as the final tick prevents that timeout.
- R9: A committed write with status bit 0 clears the status. A committed write with status bit 1 leaves it unchanged. Only `rst_n` otherwise clears it.
- R10: A `psm_evt` pulse clears enable and the counter, and no request follows while the watchdog stays disabled.
- R11: `bus_rdata` shows the register combinationally whenever `bus_addr` selects it, and reads 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External hardware reset, active low, asynchronous |
| tick | input | 1 | 32.768 kHz timebase enable, one clock wide |
| psm_evt | input | 1 | Power-supply-monitor interrupt event |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| rst_req | output | 1 | System reset request pulse |
| irq_req | output | 1 | Non-maskable interrupt request pulse |

## Verification
If the armed flag is wrong, it shows at the very next register read: bit 0 is wrong, or a protected write lands or vanishes when it should not. If the count or the prescale decode is wrong, the reset or interrupt pulse moves by at least one cycle from 2^(p+9) ticks. The bench measures that position exactly for every code. Mistakes in the status or enable updates show at the first readback after a timeout, a power event or a hardware reset.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hC0,
  parameter int BASE_SH = 9,
  parameter int NUM_CODES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              psm_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              rst_req,
  output logic              irq_req
);
  localparam int CNT_W = BASE_SH + NUM_CODES - 1;
  localparam logic [3:0] IMM_CODE = 4'(NUM_CODES);

  logic [3:0]       pre;
  logic             imode, stat, en, armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   lim, last;

  wire sel     = bus_addr == REG_ADDR;
  wire commit  = armed && bus_wr && sel;
  wire arm_set = !armed && bus_wr && sel && bus_wdata[0];
  wire valid   = pre < IMM_CODE;
  wire imm     = pre == IMM_CODE;

  assign lim  = {{CNT_W{1'b0}}, 1'b1} << (BASE_SH + 32'(pre));
  assign last = lim - {{CNT_W{1'b0}}, 1'b1};

  wire hit = en && !commit && !psm_evt &&
             (imm || (valid && tick && ({1'b0, cnt} == last)));

  assign bus_rdata = sel ? {pre, imode, stat, en, armed} : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= 4'h1;
      imode   <= 1'b0;
      stat    <= 1'b0;
      en      <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      rst_req <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      rst_req <= hit && (imm || !imode);
      irq_req <= hit && !imm && imode;
      armed   <= arm_set;
      if (commit) begin
        pre   <= bus_wdata[7:4];
        imode <= bus_wdata[3];
        stat  <= stat & bus_wdata[2];
        en    <= bus_wdata[1];
        cnt   <= '0;
      end else if (hit) begin
        stat <= 1'b1;
        cnt  <= '0;
        if (imm || !imode) en <= 1'b0;
      end else if (en && valid && tick) begin
        cnt <= cnt + 1'b1;
      end
      if (psm_evt) begin
        en  <= 1'b0;
        cnt <= '0;
      end
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq_req)); // R5
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R4
  AST_RST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!en && stat)); // R4
  AST_IRQ_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en && stat)); // R5
  AST_ARM_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (bus_wr || bus_rd)) |=> !armed); // R2
  AST_PSM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    psm_evt |=> !en); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (en && valid) |-> ({1'b0, cnt} < lim)); // R3
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !imm) |=> !(rst_req || irq_req)); // R7
endmodule

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  localparam int CLK_P = 10;
  localparam logic [7:0] REG = 8'hC0;
  localparam logic [4:0] VEC [0:7] = '{5'h00, 5'h03, 5'h04, 5'h07,
                                       5'h08, 5'h0B, 5'h0C, 5'h0F};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, psm_evt = 1'b0;
  logic [7:0] bus_addr = REG, bus_wdata = 8'h00, bus_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0, rst_req, irq_req;
  int n_chk = 0, n_fail = 0;

  wdt_guard i_wdt_guard (.clk(clk), .rst_n(rst_n), .tick(tick), .psm_evt(psm_evt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .irq_req(irq_req));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = REG;
  endtask

  task automatic prot_write(input logic [7:0] d);
    bus_write(REG, 8'h01);
    bus_write(REG, d);
  endtask

  task automatic bus_read(output logic [7:0] d);
    bus_addr = REG; bus_rd = 1'b1; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic measure(input int maxc, output int n, output logic sr, output logic si);
    n = 0; sr = 1'b0; si = 1'b0;
    while (n < maxc && !sr && !si) begin
      @(negedge clk); n++; sr = rst_req; si = irq_req;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n; logic sr, si; logic [7:0] rd; logic seen;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    bus_read(rd);
    chk("R1 reset value", rd, 8'h10);
    chk("R1 outputs idle", {rst_req, irq_req}, 0);

    // R3 R4 R5 expiry per prescale code
    foreach (VEC[i]) begin
      logic [3:0] p; logic im; int lim;
      p = VEC[i][4:1]; im = VEC[i][0]; lim = 1 << (9 + p);
      hw_reset();
      bus_read(rd);
      chk("R9 status cleared by hw reset", rd, 8'h10);
      tick = 1'b1;
      prot_write({p, im, 1'b0, 1'b1, 1'b0});
      measure(lim + 5, n, sr, si);
      chk("R3 timeout cycle", n, lim);
      chk(im ? "R5 irq selected" : "R4 reset selected", {sr, si}, im ? 1 : 2);
      @(negedge clk);
      chk("R4 R5 single pulse", {rst_req, irq_req}, 0);
      tick = 1'b0;
      bus_read(rd);
      chk(im ? "R5 enable kept" : "R4 enable cleared status set", rd,
          {p, im, 1'b1, im, 1'b0});
    end

    // R5 periodic interrupt
    hw_reset(); tick = 1'b1;
    prot_write(8'h0A);
    measure(600, n, sr, si);
    chk("R5 first irq", {n, sr, si}, {32'd512, 1'b0, 1'b1});
    measure(600, n, sr, si);
    chk("R5 second irq", {n, sr, si}, {32'd512, 1'b0, 1'b1});

    // R8 refresh on the last tick
    hw_reset();
    prot_write(8'h02);
    seen = 1'b0;
    repeat (510) begin @(negedge clk); seen |= rst_req; end
    prot_write(8'h02);
    seen |= rst_req;
    chk("R8 no timeout with late refresh", seen, 0);
    measure(600, n, sr, si);
    chk("R8 count restarted", {n, sr}, {32'd512, 1'b1});
    tick = 1'b0;

    // R6 immediate reset code
    hw_reset();
    prot_write(8'h8A);
    chk("R6 not before commit edge", rst_req, 0);
    @(negedge clk);
    chk("R6 immediate reset", {rst_req, irq_req}, 2);
    @(negedge clk);
    chk("R6 single pulse", rst_req, 0);
    bus_read(rd);
    chk("R6 enable cleared status set", rd, 8'h8C);

    // R9 status write rules
    prot_write(8'h84);
    bus_read(rd);
    chk("R9 write 1 keeps status", rd, 8'h84);
    prot_write(8'h80);
    bus_read(rd);
    chk("R9 write 0 clears status", rd, 8'h80);

    // R2 R11 locked writes
    hw_reset();
    bus_write(REG, 8'h02);
    bus_read(rd);
    chk("R2 unarmed write ignored", rd, 8'h10);
    bus_write(REG, 8'h01);
    bus_read(rd);
    chk("R11 armed flag visible", rd, 8'h11);
    bus_write(REG, 8'h22);
    bus_read(rd);
    chk("R2 read cancels arming", rd, 8'h10);
    bus_write(REG, 8'h01);
    bus_write(8'h55, 8'h00);
    bus_write(REG, 8'h22);
    bus_read(rd);
    chk("R2 other address cancels arming", rd, 8'h10);
    prot_write(8'h20);
    bus_read(rd);
    chk("R2 armed write commits", rd, 8'h20);
    bus_addr = 8'h33; #1;
    chk("R11 other address reads zero", bus_rdata, 8'h00);
    @(negedge clk); bus_addr = REG;

    // R7 reserved code
    hw_reset(); tick = 1'b1;
    prot_write(8'h92);
    measure(700, n, sr, si);
    chk("R7 reserved never expires", {sr, si}, 0);

    // R10 power monitor event
    hw_reset();
    prot_write(8'h02);
    repeat (300) @(negedge clk);
    psm_evt = 1'b1; @(negedge clk); psm_evt = 1'b0;
    tick = 1'b0;
    bus_read(rd);
    chk("R10 enable cleared", rd, 8'h00);
    tick = 1'b1;
    measure(700, n, sr, si);
    chk("R10 no request after event", {sr, si}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule